// File: doc/BRIEF.md
# Saturating Fixed-Point PID Duty Regulator

This block closes a voltage loop in discrete time. On each enabled rising edge of its sampling clock it takes a signed error sample and updates a clamped integral sum. It then forms proportional, integral and derivative terms from three signed fixed-point gain words and maps their sum onto an unsigned duty word for a pulse-width modulator. The error is read as a signed fraction of full scale: a count of +511 means just under 1.0 and -512 means -1.0.

Each gain is a signed word with three integer and three fractional bits. Each of the three products is also scaled down by a fixed power of two, chosen per term. This lets small real gains such as 0.12 or 0.03 use the full 6-bit word. The three terms are brought to a common fraction of nine bits and added. A negative sum produces zero duty, a sum of 1.0 or more produces full duty, and any other sum supplies its fraction as the duty word.

Top module: `sat_pid_ctrl`

## Requirements
- R1: A high `rst` at a rising edge clears the integral sum, the stored previous error and `duty_o` to zero, whatever the level of `ce`.
- R2: With `ce` low and `rst` low at a rising edge, the integral sum, the stored previous error and `duty_o` keep their values.
- R3: On an enabled edge the integral sum becomes S + E, clamped to the range -2048 to +2047. The sum is 12 bits, two's complement, and it never wraps.
- R4: Gains are 6-bit two's complement words with 3 fractional bits. With E the error, S' the new integral sum and Ep the stored previous error, all as signed counts, the terms are P = floor(kp*E/16), I = floor(ki*S'/512) and D = floor(kd*(E-Ep)/512). Each term is in units of 1/512, and the sum is P+I+D.
- R5: A negative sum gives `duty_o` = 0.
- R6: A sum of 512 or more gives `duty_o` = 1023.
- R7: A sum from 0 to 511 gives `duty_o` = 2*sum. The nine fraction bits fill the upper bits and bit 0 is 0. Bit 0 of `duty_o` is therefore 1 only at full duty.
- R8: `duty_o` is registered. Input changes reach it only at the next enabled rising edge of `clk`, and the stored previous error takes that edge's error sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for all state |
| err_i | input | 10 | Error sample, two's complement fraction of full scale |
| kp_i | input | 6 | Proportional gain, signed 3.3 |
| ki_i | input | 6 | Integral gain, signed 3.3 |
| kd_i | input | 6 | Derivative gain, signed 3.3 |
| duty_o | output | 10 | Clamped duty word |

## Verification
On every cycle, the assertions check several invariants. The state holds while the enable is low. The integral sum never wraps across its sign bit, in either direction. The duty word's low bit is set only at full scale. An enabled edge whose sum is negative, or at least one, leaves zero or full duty.

The exact values need the bench's scenarios. These cover the floor rounding of each term, the derivative's use of the stored previous error, and the duty readback after the integral sum has run into its positive and negative limits. They also cover the 511/512 boundary of the output clamp and the clearing of state by reset while the enable is low.

// File: rtl/sat_pid_pkg.sv
package sat_pid_pkg;

    typedef enum logic [1:0] {
        CLAMP_ZERO = 2'd0,
        CLAMP_PASS = 2'd1,
        CLAMP_FULL = 2'd2
    } clamp_sel_e;

    localparam int TERM_COUNT = 3;
    localparam int TERM_P     = 0;
    localparam int TERM_I     = 1;
    localparam int TERM_D     = 2;

    localparam logic [5:0] GAIN_P_INIT = 6'b000010;
    localparam logic [5:0] GAIN_I_INIT = 6'b011111;
    localparam logic [5:0] GAIN_D_INIT = 6'b001101;

endpackage

// File: rtl/sat_pid_integ.sv
module sat_pid_integ #(
    parameter int ERR_W = 10,
    parameter int SUM_W = 12
) (
    input  logic signed [ERR_W-1:0] err_i,
    input  logic signed [SUM_W-1:0] acc_i,
    output logic signed [SUM_W-1:0] acc_o
);
    localparam int XW = SUM_W + 1;
    localparam logic signed [XW-1:0] LIM_HI = XW'((2 ** (SUM_W - 1)) - 1);
    localparam logic signed [XW-1:0] LIM_LO = -LIM_HI - XW'(1);

    logic signed [XW-1:0] wide_sum;

    always_comb begin
        wide_sum = {{(XW - ERR_W){err_i[ERR_W-1]}}, err_i}
                 + {acc_i[SUM_W-1], acc_i};
        if (wide_sum > LIM_HI) begin
            acc_o = LIM_HI[SUM_W-1:0];
        end else if (wide_sum < LIM_LO) begin
            acc_o = LIM_LO[SUM_W-1:0];
        end else begin
            acc_o = wide_sum[SUM_W-1:0];
        end
    end

endmodule

// File: rtl/sat_pid_term.sv
module sat_pid_term #(
    parameter int IN_W   = 13,
    parameter int GAIN_W = 6,
    parameter int SHIFT  = 4,
    parameter int OUT_W  = 21
) (
    input  logic signed [IN_W-1:0]   val_i,
    input  logic signed [GAIN_W-1:0] gain_i,
    output logic signed [OUT_W-1:0]  term_o
);
    localparam int PW = IN_W + GAIN_W;

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] scaled;

    always_comb begin
        prod   = $signed({{GAIN_W{val_i[IN_W-1]}}, val_i})
               * $signed({{IN_W{gain_i[GAIN_W-1]}}, gain_i});
        scaled = prod >>> SHIFT;
        term_o = {{(OUT_W - PW){scaled[PW-1]}}, scaled};
    end

endmodule

// File: rtl/sat_pid_clamp.sv
module sat_pid_clamp
    import sat_pid_pkg::*;
#(
    parameter int ACC_W  = 21,
    parameter int FRAC_W = 9,
    parameter int DUTY_W = 10
) (
    input  logic signed [ACC_W-1:0] sum_i,
    output logic [DUTY_W-1:0]       duty_o,
    output clamp_sel_e              sel_o
);
    localparam int PAD_W = DUTY_W - FRAC_W;

    always_comb begin
        if (sum_i[ACC_W-1]) begin
            sel_o  = CLAMP_ZERO;
            duty_o = '0;
        end else if (|sum_i[ACC_W-2:FRAC_W]) begin
            sel_o  = CLAMP_FULL;
            duty_o = '1;
        end else begin
            sel_o  = CLAMP_PASS;
            duty_o = {sum_i[FRAC_W-1:0], {PAD_W{1'b0}}};
        end
    end

endmodule

// File: rtl/sat_pid_ctrl.sv
module sat_pid_ctrl
    import sat_pid_pkg::*;
#(
    parameter int ERR_W     = 10,
    parameter int SUM_W     = 12,
    parameter int GAIN_W    = 6,
    parameter int GAIN_FRAC = 3,
    parameter int P_SHIFT   = 1,
    parameter int I_SHIFT   = 6,
    parameter int D_SHIFT   = 6,
    parameter int DUTY_W    = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic [ERR_W-1:0]  err_i,
    input  logic [GAIN_W-1:0] kp_i,
    input  logic [GAIN_W-1:0] ki_i,
    input  logic [GAIN_W-1:0] kd_i,
    output logic [DUTY_W-1:0] duty_o
);
    localparam int FRAC_W = ERR_W - 1;
    localparam int IN_W   = SUM_W + 1;
    localparam int ACC_W  = IN_W + GAIN_W + 2;

    typedef struct packed {
        logic signed [SUM_W-1:0] integ;
        logic signed [ERR_W-1:0] eprev;
        logic [DUTY_W-1:0]       duty;
    } state_t;

    state_t st_d, st_q;

    logic signed [SUM_W-1:0]  integ_next;
    logic signed [IN_W-1:0]   term_in  [TERM_COUNT];
    logic signed [GAIN_W-1:0] term_gain[TERM_COUNT];
    logic signed [ACC_W-1:0]  term_out [TERM_COUNT];
    logic signed [ACC_W-1:0]  acc_sum;
    logic [DUTY_W-1:0]        duty_calc;
    clamp_sel_e               clamp_sel;

    sat_pid_integ #(
        .ERR_W (ERR_W),
        .SUM_W (SUM_W)
    ) u_integ (
        .err_i (err_i),
        .acc_i (st_q.integ),
        .acc_o (integ_next)
    );

    always_comb begin
        term_in[TERM_P]   = {{(IN_W - ERR_W){err_i[ERR_W-1]}}, err_i};
        term_in[TERM_I]   = {{(IN_W - SUM_W){integ_next[SUM_W-1]}}, integ_next};
        term_in[TERM_D]   = {{(IN_W - ERR_W){err_i[ERR_W-1]}}, err_i}
                          - {{(IN_W - ERR_W){st_q.eprev[ERR_W-1]}}, st_q.eprev};
        term_gain[TERM_P] = kp_i;
        term_gain[TERM_I] = ki_i;
        term_gain[TERM_D] = kd_i;
    end

    for (genvar gi = 0; gi < TERM_COUNT; gi++) begin : g_term
        localparam int EXTRA = (gi == TERM_P) ? P_SHIFT
                             : (gi == TERM_I) ? I_SHIFT : D_SHIFT;
        sat_pid_term #(
            .IN_W   (IN_W),
            .GAIN_W (GAIN_W),
            .SHIFT  (GAIN_FRAC + EXTRA),
            .OUT_W  (ACC_W)
        ) u_term (
            .val_i  (term_in[gi]),
            .gain_i (term_gain[gi]),
            .term_o (term_out[gi])
        );
    end

    always_comb begin
        acc_sum = term_out[TERM_P] + term_out[TERM_I] + term_out[TERM_D];
    end

    sat_pid_clamp #(
        .ACC_W  (ACC_W),
        .FRAC_W (FRAC_W),
        .DUTY_W (DUTY_W)
    ) u_clamp (
        .sum_i  (acc_sum),
        .duty_o (duty_calc),
        .sel_o  (clamp_sel)
    );

    always_comb begin
        st_d = st_q;
        if (ce) begin
            st_d.integ = integ_next;
            st_d.eprev = err_i;
            st_d.duty  = duty_calc;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign duty_o = st_q.duty;

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !ce |=> ($stable(st_q.integ) && $stable(st_q.eprev) && $stable(duty_o))); // R2

    AST_NO_WRAP_POS: assert property (@(posedge clk) disable iff (rst)
        (ce && !err_i[ERR_W-1] && !st_q.integ[SUM_W-1]) |=> !st_q.integ[SUM_W-1]); // R3

    AST_NO_WRAP_NEG: assert property (@(posedge clk) disable iff (rst)
        (ce && err_i[ERR_W-1] && st_q.integ[SUM_W-1]) |=> st_q.integ[SUM_W-1]); // R3

    AST_NEG_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (ce && clamp_sel == CLAMP_ZERO) |=> (duty_o == '0)); // R5

    AST_OVER_TO_FULL: assert property (@(posedge clk) disable iff (rst)
        (ce && clamp_sel == CLAMP_FULL) |=> (&duty_o)); // R6

    AST_LSB_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
        duty_o[0] |-> (&duty_o)); // R7

endmodule

// File: tb/sat_pid_ctrl_bench.sv
`timescale 1ns/1ps
module sat_pid_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       ce;
    logic [9:0] err_i;
    logic [5:0] kp_i, ki_i, kd_i;
    logic [9:0] duty_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    sat_pid_ctrl u_sat_pid_ctrl (
        .clk    (clk),
        .rst    (rst),
        .ce     (ce),
        .err_i  (err_i),
        .kp_i   (kp_i),
        .ki_i   (ki_i),
        .kd_i   (kd_i),
        .duty_o (duty_o)
    );

    localparam int N = 23;
    localparam int V_CE [N] = '{1,1,1,1,0,1,1,1,1,1, 1,1,1,1,1,1,1,1,1,1, 1,1,1};
    localparam int V_ERR[N] = '{100,100,-50,511,300,0,511,511,511,0,
                                -512,-512,-512,-512,-512,-512,-512,-512,-512,-512,
                                0,481,482};
    localparam int V_KP [N] = '{2,2,2,31,0,0,0,0,0,0, 0,0,0,0,0,0,0,0,0,0, 0,17,17};
    localparam int V_KI [N] = '{31,31,31,0,0,8,0,0,0,8, 0,0,0,0,0,0,0,0,0,0, -8,0,0};
    localparam int V_KD [N] = '{13,13,13,0,0,8,0,0,0,0, 0,0,0,0,0,0,0,0,0,0, 0,0,0};
    localparam int V_EXP[N] = '{40,48,0,1023,1023,4,0,0,0,62, 0,0,0,0,0,0,0,0,0,0, 64,1022,1023};
    localparam int V_TAG[N] = '{4,4,5,6,2,2,3,3,3,3, 3,3,3,3,3,3,3,3,3,3, 3,7,6};

    function automatic string tag_of(int t);
        case (t)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string tag, logic [9:0] act, logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s duty=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(int c, int e, int p, int i, int d);
        ce    = c[0];
        err_i = 10'(e);
        kp_i  = 6'(p);
        ki_i  = 6'(i);
        kd_i  = 6'(d);
    endtask

    initial begin
        rst = 1'b1;
        drive(0, 0, 0, 0, 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", duty_o, 10'd0);
        rst = 1'b0;

        for (int k = 0; k < N; k++) begin
            drive(V_CE[k], V_ERR[k], V_KP[k], V_KI[k], V_KD[k]);
            @(posedge clk);
            @(negedge clk);
            check(tag_of(V_TAG[k]), duty_o, 10'(V_EXP[k]));
        end

        // R1: reset with ce low clears duty and state
        rst = 1'b1;
        drive(0, 0, 0, 0, 0);
        @(posedge clk);
        @(negedge clk);
        check("R1", duty_o, 10'd0);
        rst = 1'b0;

        // R8: new inputs do not reach the output before the edge
        drive(1, 64, 0, 8, 8);
        #5;
        check("R8", duty_o, 10'd0);
        @(posedge clk);
        @(negedge clk);
        // R1: S and previous error start from zero: I=1, D=1 -> duty 4
        check("R1", duty_o, 10'd4);

        // R8: stored previous error is this edge's sample (64): D = floor(8*(0-64)/512) = -1
        drive(1, 0, 0, 0, 8);
        @(posedge clk);
        @(negedge clk);
        check("R8", duty_o, 10'd0);
        drive(1, 100, 0, 0, 16);
        @(posedge clk);
        @(negedge clk);
        // D = floor(16*100/512) = 3 -> duty 6
        check("R4", duty_o, 10'd6);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R8 watchdog duty=%0d expected=finish", duty_o);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule